// File: doc/BRIEF.md
# Oversampling Serial Receiver with Start Validation

This block recovers bytes from an asynchronous serial line. A sampling tick, produced elsewhere, strobes the receiver a fixed number of times per bit: 8 ticks per bit in the fast setting and 16 in the slow setting. A falling line is treated only as a candidate start bit. It becomes a real start bit after the line has stayed low for half a bit period. From that point each data bit is sampled once, near its centre, and the stop bit is checked the same way.

The received byte, a full flag, a framing-error flag and a combined interrupt request appear on the outputs. Receive-enable only decides whether a new frame may begin, so a frame already arriving always runs to its end. A line stuck low yields a framing error for every frame period, and the error comes back even after it has been cleared. The line input is taken as already synchronous to `clk`.

Top module: `uart_rx_sampler`

## Requirements
- R1: After reset, rxData is 0x00 and rxFull, frameErr and rxIrq are all 0.
- R2: With slowMode=0 a bit lasts 8 sampling ticks. With slowMode=1 it lasts 16. Frames sent at the matching rate are received correctly in both settings.
- R3: A start bit is accepted only after the line reads low on a number of consecutive ticks equal to half a bit (4 or 8). If the line reads high earlier, the candidate is dropped, the receiver returns to idle, and it looks for the next low level.
- R4: Each data bit is sampled once, one full bit period after the previous sample point (the first sample is one bit after start acceptance). Bits arrive least significant first, so the first data bit lands in rxData[0].
- R5: While rxEnable is 0, no new frame starts and rxFull stays unchanged. Clearing rxEnable during a frame still lets that frame complete and be stored.
- R6: A low stop-bit sample sets frameErr. The byte is still written to rxData and rxFull is still set.
- R7: At the stop-bit sample, rxData takes the assembled byte and rxFull becomes 1 on the same clock edge.
- R8: A one-cycle pulse on clearErr clears frameErr and leaves rxFull alone. A pulse on readAck clears rxFull. A flag being set on the same cycle overrides its clear.
- R9: rxIrq is 1 exactly when rxFull or frameErr is 1.
- R10: With the line held low, the receiver keeps framing frames: each one gives rxData 0x00 and sets frameErr. After a clear, frameErr is set again at the next stop-bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle sampling strobe from the rate divider |
| rxLine | input | 1 | Serial input, idle high, synchronous to clk |
| rxEnable | input | 1 | Allows new frames to begin |
| slowMode | input | 1 | 0: 8 ticks per bit, 1: 16 ticks per bit |
| clearErr | input | 1 | Write-one pulse clearing frameErr |
| readAck | input | 1 | Pulse clearing rxFull after the byte is taken |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | A byte is waiting |
| frameErr | output | 1 | A stop bit was sampled low |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters: 8 data bits and tick counts of 8 and 16. It produces one tick every four clocks, so both the half-bit validation window and the full-bit spacing cover several clocks. A glitch three ticks long falls one tick short of the fast validation window. The bench also shortens a low stop bit so that the low level left after its sample stays shorter than that window. Holding the line low for many bit periods brings the repeated-error behaviour within reach.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic sampleBit;
    logic commitFrame;
  } rxStrobes_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int TICKS_FAST = 8,
  parameter int TICKS_SLOW = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       rxEnable,
  input  logic       slowMode,
  output rxStrobes_t strobes
);

  localparam int CW = $clog2(TICKS_SLOW);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(TICKS_FAST - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(TICKS_SLOW - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(TICKS_FAST / 2 - 1);
  localparam logic [CW-1:0] SLOW_HALF = CW'(TICKS_SLOW / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic [CW-1:0] bitLast;
  logic [CW-1:0] halfLast;
  logic          atBitEnd;

  assign bitLast  = slowMode ? SLOW_LAST : FAST_LAST;
  assign halfLast = slowMode ? SLOW_HALF : FAST_HALF;
  assign atBitEnd = (tickCnt == bitLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        RX_IDLE: begin
          if (rxEnable && !rxLine) begin
            state   <= RX_START;
            tickCnt <= CW'(1);
          end
        end
        RX_START: begin
          if (rxLine) begin
            state   <= RX_IDLE;
            tickCnt <= '0;
          end else if (tickCnt == halfLast) begin
            state   <= RX_DATA;
            tickCnt <= '0;
            bitIdx  <= '0;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        RX_DATA: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            if (bitIdx == LAST_BIT) state <= RX_STOP;
            else bitIdx <= bitIdx + BW'(1);
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        RX_STOP: begin
          if (atBitEnd) begin
            state   <= RX_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.sampleBit   = sampleTick && (state == RX_DATA) && atBitEnd;
    strobes.commitFrame = sampleTick && (state == RX_STOP) && atBitEnd;
  end

  // Checker state: data samples counted since start acceptance
  logic [BW-1:0] bitsSeen;
  always_ff @(posedge clk) begin
    if (!rstN) bitsSeen <= '0;
    else if (state == RX_START && sampleTick && !rxLine && tickCnt == halfLast) bitsSeen <= '0;
    else if (strobes.sampleBit) bitsSeen <= bitsSeen + BW'(1);
  end

  p_drop_on_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && sampleTick && rxLine) |=> (state == RX_IDLE));

  p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && !rxEnable) |=> (state == RX_IDLE));

  p_bit_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitFrame |-> (bitsSeen == BW'(DATA_BITS)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.sampleBit && strobes.commitFrame));

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobes_t           strobes,
  input  logic                 clearErr,
  input  logic                 readAck,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 frameErr
);

  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobes.sampleBit) shiftReg <= {rxLine, shiftReg[DATA_BITS-1:1]};
      if (strobes.commitFrame) rxData <= shiftReg;

      if (strobes.commitFrame) rxFull <= 1'b1;
      else if (readAck)        rxFull <= 1'b0;

      if (strobes.commitFrame && !rxLine) frameErr <= 1'b1;
      else if (clearErr)                  frameErr <= 1'b0;
    end
  end

  p_commit_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitFrame |=> (rxFull && rxData == $past(shiftReg)));

  p_stop_low_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitFrame && !rxLine) |=> frameErr);

  p_clear_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearErr && !strobes.commitFrame) |=> !frameErr);

  p_ack_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !strobes.commitFrame) |=> !rxFull);

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitFrame |=> $stable(rxData));

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int TICKS_FAST = 8,
  parameter int TICKS_SLOW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 slowMode,
  input  logic                 clearErr,
  input  logic                 readAck,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 frameErr,
  output logic                 rxIrq
);

  rxStrobes_t strobes;

  uart_rx_ctrl #(
    .DATA_BITS (DATA_BITS),
    .TICKS_FAST(TICKS_FAST),
    .TICKS_SLOW(TICKS_SLOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxLine    (rxLine),
    .rxEnable  (rxEnable),
    .slowMode  (slowMode),
    .strobes   (strobes)
  );

  uart_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxLine  (rxLine),
    .strobes (strobes),
    .clearErr(clearErr),
    .readAck (readAck),
    .rxData  (rxData),
    .rxFull  (rxFull),
    .frameErr(frameErr)
  );

  assign rxIrq = rxFull | frameErr;

endmodule

// File: tb/uart_rx_sampler_test.sv
module uart_rx_sampler_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV    = 4;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b1;
  logic       slowMode = 1'b0;
  logic       clearErr = 1'b0;
  logic       readAck = 1'b0;
  logic [7:0] rxData;
  logic       rxFull;
  logic       frameErr;
  logic       rxIrq;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) tickCnt <= 0;
    else tickCnt <= (tickCnt == TICKDIV-1) ? 0 : tickCnt + 1;
  end
  assign sampleTick = rstN && (tickCnt == TICKDIV-1);

  uart_rx_sampler uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .slowMode(slowMode), .clearErr(clearErr),
    .readAck(readAck), .rxData(rxData), .rxFull(rxFull),
    .frameErr(frameErr), .rxIrq(rxIrq)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n*TICKDIV) @(negedge clk);
  endtask

  task automatic pulseAck();
    readAck = 1'b1; @(negedge clk); readAck = 1'b0; @(negedge clk);
  endtask

  task automatic pulseClear();
    clearErr = 1'b1; @(negedge clk); clearErr = 1'b0; @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] data, input bit stopLow,
                           input int tpb, input int dropAt);
    rxLine = 1'b0;
    waitTicks(tpb);
    for (int i = 0; i < 8; i++) begin
      if (i == dropAt) rxEnable = 1'b0;
      rxLine = data[i];
      waitTicks(tpb);
    end
    if (stopLow) begin
      rxLine = 1'b0;
      waitTicks(tpb*3/4);
    end
    rxLine = 1'b1;
    waitTicks(tpb*2);
  endtask

  task automatic testReset();
    checkEq("R1 rxData", rxData, 8'h00);
    checkEq("R1 rxFull", rxFull, 0);
    checkEq("R1 frameErr", frameErr, 0);
    checkEq("R1 rxIrq", rxIrq, 0);
  endtask

  task automatic testFast();
    slowMode = 1'b0;
    sendFrame(8'hA5, 1'b0, 8, -1);
    checkEq("R2 R4 fast data A5", rxData, 8'hA5);
    checkEq("R7 rxFull set", rxFull, 1);
    checkEq("R9 irq on full", rxIrq, 1);
    checkEq("R6 no error on good stop", frameErr, 0);
    pulseAck();
    checkEq("R8 readAck clears rxFull", rxFull, 0);
    checkEq("R9 irq idle", rxIrq, 0);
    sendFrame(8'h01, 1'b0, 8, -1);
    checkEq("R4 lsb first 01", rxData, 8'h01);
    pulseAck();
  endtask

  task automatic testSlow();
    slowMode = 1'b1;
    sendFrame(8'h96, 1'b0, 16, -1);
    checkEq("R2 slow data 96", rxData, 8'h96);
    pulseAck();
    sendFrame(8'h80, 1'b0, 16, -1);
    checkEq("R4 slow msb 80", rxData, 8'h80);
    pulseAck();
    slowMode = 1'b0;
  endtask

  task automatic testGlitch();
    rxLine = 1'b0;
    waitTicks(3);
    rxLine = 1'b1;
    waitTicks(8*12);
    checkEq("R3 short low ignored", rxFull, 0);
    checkEq("R3 data unchanged", rxData, 8'h80);
    sendFrame(8'h5A, 1'b0, 8, -1);
    checkEq("R3 detection restarts", rxData, 8'h5A);
    pulseAck();
  endtask

  task automatic testDisable();
    sendFrame(8'hC3, 1'b0, 8, 3);
    checkEq("R5 frame completes after disable", rxData, 8'hC3);
    checkEq("R5 full after disable", rxFull, 1);
    pulseAck();
    sendFrame(8'h77, 1'b0, 8, -1);
    checkEq("R5 no frame while disabled", rxFull, 0);
    checkEq("R5 data kept while disabled", rxData, 8'hC3);
    rxEnable = 1'b1;
  endtask

  task automatic testStopErr();
    sendFrame(8'hE7, 1'b1, 8, -1);
    checkEq("R6 frameErr on low stop", frameErr, 1);
    checkEq("R6 byte still stored", rxData, 8'hE7);
    checkEq("R6 full still set", rxFull, 1);
    pulseClear();
    checkEq("R8 clearErr clears frameErr", frameErr, 0);
    checkEq("R8 clearErr keeps rxFull", rxFull, 1);
    checkEq("R9 irq from full only", rxIrq, 1);
    pulseAck();
  endtask

  task automatic testHeldLow();
    rxLine = 1'b0;
    waitTicks(8*11);
    checkEq("R10 error with line low", frameErr, 1);
    checkEq("R10 zero byte", rxData, 8'h00);
    pulseClear();
    pulseAck();
    checkEq("R10 cleared", frameErr, 0);
    waitTicks(8*11);
    checkEq("R10 error returns", frameErr, 1);
    checkEq("R9 irq on error", rxIrq, 1);
    rxLine = 1'b1;
    waitTicks(8*12);
    pulseClear();
    pulseAck();
    checkEq("R9 irq released", rxIrq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFast();
    testSlow();
    testGlitch();
    testDisable();
    testStopErr();
    testHeldLow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule